// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

This peripheral passes whole packets between a processor and a line-side byte stream. Every data transfer is a single register access. The processor sees a small register window on a 32-bit read/write bus. The line side has one byte-wide receive stream and one byte-wide transmit stream, each with valid/ready handshake and first/last-byte markers. The block holds one inbound packet and one outbound packet in internal byte buffers.

To receive, software reads a byte count and then reads the receive data port that many times. Each read returns the next byte and lowers the count by one. To transmit, software writes the packet length and then writes that many bytes to the transmit data port. Once the last byte arrives, the block streams the packet out. A status register records transmit-done, receive-available and a software test event. The OR of these drives a level interrupt output.

Top module: `pkt_mailbox`

## Requirements
- R1: Reads return fixed values at these addresses. 0x00 returns 0x424F5831 and 0x04 returns 0x504B544D; together these form the 64-bit ASCII name "PKTMBOX1", with the last character as version. 0x18 returns parameter IRQ_INDEX (default 3).
- R2: After reset, every register reads 0 except the fixed words of R1. Unmapped addresses read 0.
- R3: Bytes are accepted on the receive stream while bit 1 of the interrupt-control register (0x14) is clear. When the last byte (eop) is accepted, the receive count at 0x0C is loaded with the packet length (capped at BUF_DEPTH), bit 1 is set, and the interrupt output rises.
- R4: A read of the receive data port at 0x1C returns the next stored byte in bits 7:0, with bits 31:8 zero. It also lowers the receive count by one. When the count is 0, a read returns 0 and changes nothing.
- R5: While bit 1 is set, rx_ready is low and no received byte is taken. Writing 1 to bit 1 clears it and discards any unread bytes, so the count becomes 0.
- R6: A write to the transmit count (0x10) is accepted only if the count is currently 0 and the value lies in 1..min(BUF_DEPTH, MAX_COUNT). Other count writes are ignored.
- R7: Writes to the transmit data port (0x20) store bits 7:0 until the programmed count is reached. Writes beyond that point, and writes made while the count is 0, are discarded. The stored packet is then streamed with tx_sop on the first byte and tx_eop on the last. Data is held stable while tx_ready is low.
- R8: After the last byte is handed off, the transmit count reads 0 and bit 0 of interrupt-control is set.
- R9: The busy register at 0x08 reads 1 in two cases: from the first to the last byte of an incoming packet, and from an accepted transmit count write until its last byte is handed off. Otherwise it reads 0.
- R10: Writing 1 to bit 31 of 0x14 sets bit 31 and raises the interrupt. A read of 0x14 clears bit 31 but leaves the interrupt pending. A write with bit 31 at 0 removes the pending test interrupt.
- R11: irq is a level signal: the OR of bit 0, bit 1 and the pending test interrupt. It falls only as a result of a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Register access this cycle |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 8 | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of the packet |
| tx_eop | output | 1 | Last byte of the packet |

## Verification
The hardest cases to reach both involve the receive side while a packet is still pending. The first is offering line bytes while bit 1 is set. The stimulus holds rx_valid with a new first byte for several cycles and then confirms the count is unchanged. The second is clearing bit 1 part-way through draining. The stimulus reads only one byte of a three-byte packet before clearing, then confirms the count is 0 and the stream is open again. On the transmit side, the sink holds tx_ready low. This lets the bench probe the first byte, an extra data write and a second count write before the packet drains.

// File: rtl/pkt_mailbox.sv
module pkt_mailbox #(
  parameter int          BUF_DEPTH = 64,
  parameter int          MAX_COUNT = 65536,
  parameter int          IRQ_INDEX = 3,
  parameter logic [63:0] ID_WORD   = 64'h504B544D424F5831
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        irq,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sop,
  input  logic        rx_eop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop
);
  localparam int CW    = $clog2(MAX_COUNT + 1);
  localparam int PW    = $clog2(BUF_DEPTH);
  localparam int LW    = $clog2(BUF_DEPTH + 1);
  localparam int LIMIT = (BUF_DEPTH < MAX_COUNT) ? BUF_DEPTH : MAX_COUNT;

  localparam logic [7:0] A_IDLO = 8'h00, A_IDHI = 8'h04, A_BUSY = 8'h08,
                         A_RXCNT = 8'h0C, A_TXCNT = 8'h10, A_ICTL = 8'h14,
                         A_INFO = 8'h18, A_RXD = 8'h1C, A_TXD = 8'h20;

  logic [7:0]    rx_mem [BUF_DEPTH];
  logic [7:0]    tx_mem [BUF_DEPTH];
  logic [LW-1:0] rx_len, rx_cnt, rd_ptr, rx_idx;
  logic          rx_active, rxd;
  logic [CW-1:0] tx_cnt;
  logic [LW-1:0] tx_fill, tx_pos;
  logic          tx_send, txd, test_flag, test_irq;

  wire host_rd   = host_sel && !host_wr;
  wire host_wt   = host_sel && host_wr;
  wire rd_rx     = host_rd && host_addr == A_RXD;
  wire wr_ictl   = host_wt && host_addr == A_ICTL;
  wire rx_fire   = rx_valid && rx_ready;
  wire tx_fire   = tx_valid && tx_ready;
  wire cnt_ok    = tx_cnt == '0 && host_wdata >= 32'd1 && host_wdata <= LIMIT;
  wire fill_open = tx_cnt != '0 && !tx_send && CW'(tx_fill) < tx_cnt;
  wire fill_last = CW'(tx_fill) + CW'(1) == tx_cnt;

  assign rx_idx   = rx_sop ? '0 : rx_len;
  assign rx_ready = !rxd;
  assign irq      = txd || rxd || test_irq;
  assign tx_valid = tx_send;
  assign tx_data  = tx_mem[tx_pos[PW-1:0]];
  assign tx_sop   = tx_send && tx_pos == '0;
  assign tx_eop   = tx_send && CW'(tx_pos) + CW'(1) == tx_cnt;

  always_ff @(posedge clk) begin
    if (rx_fire && rx_idx < LW'(BUF_DEPTH)) rx_mem[rx_idx[PW-1:0]] <= rx_data;
    if (host_wt && host_addr == A_TXD && fill_open) tx_mem[tx_fill[PW-1:0]] <= host_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_len <= '0; rx_cnt <= '0; rd_ptr <= '0; rx_active <= 1'b0; rxd <= 1'b0;
      tx_cnt <= '0; tx_fill <= '0; tx_pos <= '0; tx_send <= 1'b0; txd <= 1'b0;
      test_flag <= 1'b0; test_irq <= 1'b0;
    end else begin
      if (host_rd && host_addr == A_ICTL) test_flag <= 1'b0;
      if (rd_rx && rx_cnt != '0) begin
        rx_cnt <= rx_cnt - 1'b1;
        rd_ptr <= rd_ptr + 1'b1;
      end
      if (wr_ictl) begin
        if (host_wdata[0]) txd <= 1'b0;
        if (host_wdata[1]) begin
          rxd    <= 1'b0;
          rx_cnt <= '0;
        end
        test_flag <= host_wdata[31];
        test_irq  <= host_wdata[31];
      end
      if (host_wt && host_addr == A_TXCNT && cnt_ok) begin
        tx_cnt  <= CW'(host_wdata);
        tx_fill <= '0;
      end
      if (host_wt && host_addr == A_TXD && fill_open) begin
        tx_fill <= tx_fill + 1'b1;
        if (fill_last) begin
          tx_send <= 1'b1;
          tx_pos  <= '0;
        end
      end
      if (tx_fire) begin
        if (tx_eop) begin
          tx_send <= 1'b0;
          tx_cnt  <= '0;
          tx_fill <= '0;
          txd     <= 1'b1;
        end else begin
          tx_pos <= tx_pos + 1'b1;
        end
      end
      if (rx_fire) begin
        rx_len    <= (rx_idx < LW'(BUF_DEPTH)) ? rx_idx + 1'b1 : rx_idx;
        rx_active <= !rx_eop;
        if (rx_eop) begin
          rx_cnt <= (rx_idx < LW'(BUF_DEPTH)) ? rx_idx + 1'b1 : rx_idx;
          rd_ptr <= '0;
          rxd    <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      case (host_addr)
        A_IDLO:  host_rdata = ID_WORD[31:0];
        A_IDHI:  host_rdata = ID_WORD[63:32];
        A_BUSY:  host_rdata = {31'd0, rx_active || tx_cnt != '0};
        A_RXCNT: host_rdata = 32'(rx_cnt);
        A_TXCNT: host_rdata = 32'(tx_cnt);
        A_ICTL:  host_rdata = {test_flag, 29'd0, rxd, txd};
        A_INFO:  host_rdata = 32'(IRQ_INDEX);
        A_RXD:   host_rdata = (rx_cnt != '0) ? {24'd0, rx_mem[rd_ptr[PW-1:0]]} : 32'd0;
        default: host_rdata = '0;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= LW'(BUF_DEPTH)); // R3
  AST_RXCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && rx_cnt != '0 |=> rx_cnt == $past(rx_cnt) - 1'b1); // R4
  AST_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && rx_cnt == '0 |-> host_rdata == 32'd0); // R4
  AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rxd && !(wr_ictl && host_wdata[1]) |=> rxd && rx_cnt <= $past(rx_cnt)); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eop)); // R7
  AST_TXDONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd) |-> tx_cnt == '0); // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(host_wt)); // R11
endmodule

// File: tb/sim_pkt_mailbox.sv
`timescale 1ns/100ps
module sim_pkt_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic irq, rx_ready, tx_valid, tx_sop, tx_eop;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = '0, tx_data;
  int nchk = 0, nfail = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  pkt_mailbox u0 (.clk, .rst_n, .host_sel, .host_wr, .host_addr, .host_wdata,
    .host_rdata, .irq, .rx_valid, .rx_ready, .rx_data, .rx_sop, .rx_eop,
    .tx_valid, .tx_ready, .tx_data, .tx_sop, .tx_eop);

  // {wr, addr, wdata, expected rdata, expected irq after access}
  localparam int NV = 18;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0, 32'h424F5831, 1'b0},  // R1
    {1'b0, 8'h04, 32'h0, 32'h504B544D, 1'b0},  // R1
    {1'b0, 8'h18, 32'h0, 32'h00000003, 1'b0},  // R1
    {1'b0, 8'h08, 32'h0, 32'h0, 1'b0},         // R2
    {1'b0, 8'h0C, 32'h0, 32'h0, 1'b0},         // R2
    {1'b0, 8'h10, 32'h0, 32'h0, 1'b0},         // R2
    {1'b0, 8'h14, 32'h0, 32'h0, 1'b0},         // R2
    {1'b0, 8'h1C, 32'h0, 32'h0, 1'b0},         // R2
    {1'b0, 8'h24, 32'h0, 32'h0, 1'b0},         // R2
    {1'b1, 8'h14, 32'h80000000, 32'h0, 1'b1},  // R10
    {1'b0, 8'h14, 32'h0, 32'h80000000, 1'b1},  // R10
    {1'b0, 8'h14, 32'h0, 32'h0, 1'b1},         // R10 R11
    {1'b1, 8'h14, 32'h00000003, 32'h0, 1'b0},  // R10
    {1'b1, 8'h10, 32'h0, 32'h0, 1'b0},         // R6
    {1'b0, 8'h10, 32'h0, 32'h0, 1'b0},         // R6
    {1'b1, 8'h10, 32'd65, 32'h0, 1'b0},        // R6
    {1'b0, 8'h10, 32'h0, 32'h0, 1'b0},         // R6
    {1'b0, 8'h08, 32'h0, 32'h0, 1'b0}          // R9
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    #1 r = host_rdata;
    @(posedge clk);
    #1 host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_sop = s; rx_eop = e;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check(irq == 1'b0 && tx_valid == 1'b0 && rx_ready == 1'b1, "R2 reset outputs",
          {29'd0, irq, tx_valid, rx_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][73], VEC[i][72:65], VEC[i][64:33], rd);
      if (!VEC[i][73]) check(rd == VEC[i][32:1], $sformatf("vector %0d read R1/R2/R6/R10", i), rd, VEC[i][32:1]);
      check(irq == VEC[i][0], $sformatf("vector %0d irq R10/R11", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // transmit
    bus(1'b1, 8'h20, 32'h11, rd);
    @(negedge clk); #1;
    check(tx_valid == 1'b0, "R7 data write with zero count discarded", {31'd0, tx_valid}, 32'h0);
    bus(1'b1, 8'h10, 32'd4, rd);
    bus(1'b0, 8'h10, 32'h0, rd); check(rd == 32'd4, "R6 count accepted", rd, 32'd4);
    bus(1'b0, 8'h08, 32'h0, rd); check(rd == 32'd1, "R9 busy during tx", rd, 32'd1);
    bus(1'b1, 8'h10, 32'd9, rd);
    bus(1'b0, 8'h10, 32'h0, rd); check(rd == 32'd4, "R6 count write while active ignored", rd, 32'd4);
    for (int i = 0; i < 5; i++) bus(1'b1, 8'h20, 32'hFFFFFF00 | (32'hA1 + i), rd);
    @(negedge clk); #1;
    check(tx_valid && tx_sop && !tx_eop && tx_data == 8'hA1, "R7 first byte held",
          {21'd0, tx_valid, tx_sop, tx_eop, tx_data}, {21'd0, 3'b110, 8'hA1});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); tx_ready = 1'b1; #1;
      check(tx_valid && tx_data == 8'(8'hA1 + i) && tx_sop == (i == 0) && tx_eop == (i == 3),
            "R7 streamed byte", {21'd0, tx_valid, tx_sop, tx_eop, tx_data},
            {21'd0, 1'b1, 1'(i == 0), 1'(i == 3), 8'(8'hA1 + i)});
      @(posedge clk);
    end
    @(negedge clk); tx_ready = 1'b0; #1;
    check(tx_valid == 1'b0, "R7 extra byte discarded", {31'd0, tx_valid}, 32'h0);
    bus(1'b0, 8'h10, 32'h0, rd); check(rd == 32'd0, "R8 count cleared", rd, 32'd0);
    bus(1'b0, 8'h14, 32'h0, rd); check(rd == 32'd1, "R8 tx-done bit", rd, 32'd1);
    check(irq == 1'b1, "R11 irq on tx-done", {31'd0, irq}, 32'd1);
    bus(1'b0, 8'h08, 32'h0, rd); check(rd == 32'd0, "R9 busy released", rd, 32'd0);
    bus(1'b1, 8'h14, 32'h1, rd);
    check(irq == 1'b0, "R11 irq cleared by write", {31'd0, irq}, 32'd0);

    // receive
    rx_byte(8'h31, 1'b1, 1'b0);
    bus(1'b0, 8'h08, 32'h0, rd); check(rd == 32'd1, "R9 busy during rx", rd, 32'd1);
    for (int i = 1; i < 4; i++) rx_byte(8'(8'h31 + i), 1'b0, 1'b0);
    rx_byte(8'h35, 1'b0, 1'b1);
    check(irq == 1'b1, "R3 irq on packet", {31'd0, irq}, 32'd1);
    bus(1'b0, 8'h0C, 32'h0, rd); check(rd == 32'd5, "R3 count loaded", rd, 32'd5);
    bus(1'b0, 8'h14, 32'h0, rd); check(rd == 32'd2, "R3 rx bit", rd, 32'd2);
    check(rx_ready == 1'b0, "R5 stream closed", {31'd0, rx_ready}, 32'd0);
    @(negedge clk); rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b1; rx_data = 8'h99;
    repeat (3) @(posedge clk);
    #1 rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    bus(1'b0, 8'h0C, 32'h0, rd); check(rd == 32'd5, "R5 offered byte not taken", rd, 32'd5);
    for (int i = 0; i < 5; i++) begin
      bus(1'b0, 8'h1C, 32'h0, rd);
      check(rd == 32'(8'h31 + i), "R4 data byte", rd, 32'(8'h31 + i));
      bus(1'b0, 8'h0C, 32'h0, rd);
      check(rd == 32'(4 - i), "R4 count step", rd, 32'(4 - i));
    end
    bus(1'b0, 8'h1C, 32'h0, rd); check(rd == 32'd0, "R4 empty read", rd, 32'd0);
    bus(1'b0, 8'h0C, 32'h0, rd); check(rd == 32'd0, "R4 empty read no change", rd, 32'd0);
    check(irq == 1'b1, "R11 irq held until cleared", {31'd0, irq}, 32'd1);
    bus(1'b1, 8'h14, 32'h2, rd);
    check(irq == 1'b0 && rx_ready == 1'b1, "R5 clear reopens", {30'd0, irq, rx_ready}, 32'd1);

    rx_byte(8'h41, 1'b1, 1'b0); rx_byte(8'h42, 1'b0, 1'b0); rx_byte(8'h43, 1'b0, 1'b1);
    bus(1'b0, 8'h1C, 32'h0, rd); check(rd == 32'h41, "R4 second packet first byte", rd, 32'h41);
    bus(1'b1, 8'h14, 32'h2, rd);
    bus(1'b0, 8'h0C, 32'h0, rd); check(rd == 32'd0, "R5 clear discards rest", rd, 32'd0);
    check(rx_ready == 1'b1, "R5 ready after flush", {31'd0, rx_ready}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule